// File: doc/BRIEF.md
# Out-of-Order Writeback Scoreboard

This block tracks instructions that leave the decoder one at a time in program order, go to one of several functional units (ALU, load/store, multiplier), finish in any order, and are retired to the register file in the original order. Its storage is a ring of entries addressed by an issue pointer and a commit pointer. Each entry keeps an occupancy bit, a completion bit, the target unit, the opcode, the destination and both source register indices, the result, and an exception flag.

Every functional unit has its own writeback port that carries a slot tag, so several results can land in the same cycle. While an instruction is being issued, its two source registers are looked up in the ring. The youngest in-flight producer of that register decides the answer: it either supplies its finished result for forwarding or reports that the operand is still pending. When the oldest entry is complete it is presented on the commit port. An entry that finished with an exception is reported there without a register write, and retirement then stops until the surrounding pipeline pulses the flush input.

Top module: `oow_scoreboard`

## Requirements
- R1: After reset the ring is empty: `issue_ready` is 1, `commit_valid` is 0 and `issue_tag` is 0.
- R2: Accepted issues take slot indices in increasing order modulo DEPTH (default 4), starting at 0. `issue_tag` shows the slot the next issue will take.
- R3: When DEPTH entries are held, `issue_ready` is 0. An `issue_valid` pulse in that state creates no entry, so it never commits and does not advance `issue_tag`.
- R4: Writebacks on different ports (port 0 ALU, 1 load/store, 2 multiplier) in the same cycle all take effect. The written results are visible to lookups from the next cycle on.
- R5: Only the oldest entry can commit, and only once it is complete. A finished younger entry waits behind an unfinished older one, and entries retire in issue order.
- R6: A commit presents the destination and result. `commit_we` is 1 only when there is no exception and the destination is not register 0.
- R7: A lookup on register r uses the youngest held entry with destination r. If that entry is complete, `lookup_hit` is 1 and `lookup_data` carries its result. If it is not complete, `lookup_busy` is 1. With no such entry both are 0. Index 0 of the lookup outputs serves `issue_rs1` and index 1 serves `issue_rs2`.
- R8: A lookup on register 0 never reports busy or hit, even while an entry with destination 0 is in flight.
- R9: An entry that completed with its exception flag commits with `commit_exc`=1 and `commit_we`=0. After that, no further commit occurs and `issue_ready` stays 0 until flush.
- R10: A flush pulse clears all entries and both pointers. In the next cycle `issue_tag` is 0, `issue_ready` is 1, and lookups find nothing.
- R11: A writeback tagged with a slot that holds no entry is ignored. An instruction issued into that slot later is still reported pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all entries and pointers |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | Space free and not halted |
| issue_fu | input | 2 | Target unit: 0 ALU, 1 load/store, 2 multiplier |
| issue_op | input | 4 | Opcode |
| issue_rd | input | 5 | Destination register |
| issue_rs1 | input | 5 | First source register, also lookup key 0 |
| issue_rs2 | input | 5 | Second source register, also lookup key 1 |
| issue_tag | output | 2 | Slot taken by the next issue |
| lookup_busy | output | 2 | Per source: youngest producer not complete |
| lookup_hit | output | 2 | Per source: youngest producer complete, forward |
| lookup_data | output | 2x32 | Per source: forwarded result |
| wb_valid | input | 3 | Per unit writeback strobe |
| wb_tag | input | 3x2 | Per unit slot tag |
| wb_data | input | 3x32 | Per unit result |
| wb_exc | input | 3 | Per unit exception flag |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_rd | output | 5 | Retiring destination |
| commit_data | output | 32 | Retiring result |
| commit_we | output | 1 | Register file write enable |
| commit_exc | output | 1 | Retiring entry raised an exception |

## Verification
The hardest states to reach are a full ring in which finished younger entries sit behind an unfinished oldest one, and a slot that receives a stray writeback while it is free and is then reused. The stimulus issues a long-latency load first, completes the two younger instructions on separate ports in one cycle, and fills the last slot while the load is still pending. At that point it probes forwarding for a register that has both an older finished producer and a younger pending one. It then wraps the pointers, reuses the slot that received the stray writeback, and ends on an exception commit followed by a flush.

// File: rtl/oow_sb_pkg.sv
package oow_sb_pkg;

    localparam int unsigned SB_XLEN   = 32;
    localparam int unsigned SB_DEPTH  = 4;
    localparam int unsigned SB_NUM_FU = 3;
    localparam int unsigned SB_REG_W  = 5;
    localparam int unsigned SB_OP_W   = 4;

    typedef enum logic [1:0] {
        FU_ALU = 2'd0,
        FU_LSU = 2'd1,
        FU_MUL = 2'd2
    } fu_e;

    typedef struct packed {
        logic                 valid;
        logic                 done;
        fu_e                  fu;
        logic [SB_OP_W-1:0]   op;
        logic [SB_REG_W-1:0]  rd;
        logic [SB_REG_W-1:0]  rs1;
        logic [SB_REG_W-1:0]  rs2;
        logic [SB_XLEN-1:0]   result;
        logic                 exc;
    } sb_entry_t;

    function automatic logic reg_writes(input logic [SB_REG_W-1:0] rd, input logic exc);
        return (rd != '0) && !exc;
    endfunction

endpackage

// File: rtl/sb_ptrs.sv
module sb_ptrs #(
    parameter int unsigned DEPTH = oow_sb_pkg::SB_DEPTH,
    localparam int unsigned IDXW = $clog2(DEPTH),
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            push,
    input  logic            pop,
    output logic [IDXW-1:0] wr_ptr,
    output logic [IDXW-1:0] rd_ptr,
    output logic [CNTW-1:0] count,
    output logic            full
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full = (count == CNTW'(DEPTH));
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup
    import oow_sb_pkg::*;
#(
    parameter int unsigned DEPTH = SB_DEPTH,
    localparam int unsigned IDXW = $clog2(DEPTH),
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input  sb_entry_t [DEPTH-1:0] ents,
    input  logic [IDXW-1:0]       head,
    input  logic [CNTW-1:0]       count,
    input  logic [SB_REG_W-1:0]   key,
    output logic                  busy,
    output logic                  hit,
    output logic [SB_XLEN-1:0]    data
);
    logic [IDXW-1:0] idx;

    // Walk from oldest to youngest; the last match found wins.
    always_comb begin
        busy = 1'b0;
        hit  = 1'b0;
        data = '0;
        idx  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IDXW'(k);
            if ((CNTW'(k) < count) && ents[idx].valid &&
                (ents[idx].rd == key) && (key != '0)) begin
                busy = !ents[idx].done;
                hit  = ents[idx].done;
                data = ents[idx].done ? ents[idx].result : '0;
            end
        end
    end
endmodule

// File: rtl/oow_scoreboard.sv
module oow_scoreboard
    import oow_sb_pkg::*;
#(
    parameter int unsigned DEPTH  = SB_DEPTH,
    parameter int unsigned NUM_FU = SB_NUM_FU,
    localparam int unsigned IDXW  = $clog2(DEPTH),
    localparam int unsigned CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             flush,
    input  logic                             issue_valid,
    output logic                             issue_ready,
    input  logic [1:0]                       issue_fu,
    input  logic [SB_OP_W-1:0]               issue_op,
    input  logic [SB_REG_W-1:0]              issue_rd,
    input  logic [SB_REG_W-1:0]              issue_rs1,
    input  logic [SB_REG_W-1:0]              issue_rs2,
    output logic [IDXW-1:0]                  issue_tag,
    output logic [1:0]                       lookup_busy,
    output logic [1:0]                       lookup_hit,
    output logic [1:0][SB_XLEN-1:0]          lookup_data,
    input  logic [NUM_FU-1:0]                wb_valid,
    input  logic [NUM_FU-1:0][IDXW-1:0]      wb_tag,
    input  logic [NUM_FU-1:0][SB_XLEN-1:0]   wb_data,
    input  logic [NUM_FU-1:0]                wb_exc,
    output logic                             commit_valid,
    output logic [SB_REG_W-1:0]              commit_rd,
    output logic [SB_XLEN-1:0]               commit_data,
    output logic                             commit_we,
    output logic                             commit_exc
);
    sb_entry_t [DEPTH-1:0] ent_q;
    logic [IDXW-1:0]       wr_ptr;
    logic [IDXW-1:0]       rd_ptr;
    logic [CNTW-1:0]       count;
    logic                  full;
    logic                  halt_q;
    logic                  push;
    logic                  pop;
    sb_entry_t             head;
    sb_entry_t             new_ent;

    assign issue_ready = !full && !halt_q;
    assign push        = issue_valid && issue_ready && !flush;
    assign issue_tag   = wr_ptr;

    sb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count),
        .full   (full)
    );

    always_comb begin
        new_ent        = '0;
        new_ent.valid  = 1'b1;
        new_ent.fu     = fu_e'(issue_fu);
        new_ent.op     = issue_op;
        new_ent.rd     = issue_rd;
        new_ent.rs1    = issue_rs1;
        new_ent.rs2    = issue_rs2;
    end

    // Entry storage: writebacks first, then allocation and release.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent_q  <= '0;
            halt_q <= 1'b0;
        end else begin
            for (int f = 0; f < NUM_FU; f++) begin
                if (wb_valid[f] && ent_q[wb_tag[f]].valid) begin
                    ent_q[wb_tag[f]].done   <= 1'b1;
                    ent_q[wb_tag[f]].result <= wb_data[f];
                    ent_q[wb_tag[f]].exc    <= wb_exc[f];
                end
            end
            if (pop) begin
                ent_q[rd_ptr].valid <= 1'b0;
                ent_q[rd_ptr].done  <= 1'b0;
                if (head.exc) halt_q <= 1'b1;
            end
            if (push) ent_q[wr_ptr] <= new_ent;
        end
    end

    // Operand lookup, one searcher per source register.
    logic [1:0][SB_REG_W-1:0] src_key;
    assign src_key[0] = issue_rs1;
    assign src_key[1] = issue_rs2;

    for (genvar s = 0; s < 2; s++) begin : g_src
        sb_lookup #(.DEPTH(DEPTH)) u_lookup (
            .ents  (ent_q),
            .head  (rd_ptr),
            .count (count),
            .key   (src_key[s]),
            .busy  (lookup_busy[s]),
            .hit   (lookup_hit[s]),
            .data  (lookup_data[s])
        );
    end

    // In-order retirement from the head of the ring.
    assign head         = ent_q[rd_ptr];
    assign pop          = head.valid && head.done && !halt_q && !flush;
    assign commit_valid = pop;
    assign commit_rd    = head.rd;
    assign commit_data  = head.result;
    assign commit_exc   = head.exc;
    assign commit_we    = pop && reg_writes(head.rd, head.exc);
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int unsigned IDXW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            flush,
    input logic            issue_valid,
    input logic            issue_ready,
    input logic [4:0]      issue_rs1,
    input logic [IDXW-1:0] issue_tag,
    input logic [1:0]      lookup_busy,
    input logic [1:0]      lookup_hit,
    input logic            commit_valid,
    input logic            commit_we,
    input logic            commit_exc
);
    // R2
    tag_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready && !flush) |=> (issue_tag == IDXW'($past(issue_tag) + 1'b1)));

    // R3
    tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!issue_ready && !flush) |=> $stable(issue_tag));

    // R6
    exc_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_exc) |-> !commit_we);

    // R7
    lookup_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lookup_busy[0], lookup_hit[0]}) && $onehot0({lookup_busy[1], lookup_hit[1]}));

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_rs1 == 5'd0) |-> (!lookup_busy[0] && !lookup_hit[0]));

    // R9
    halt_after_exc_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_exc && !flush) |=> (!commit_valid && !issue_ready));

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (issue_ready && !commit_valid && issue_tag == '0));
endmodule

bind oow_scoreboard sb_checker #(.IDXW(IDXW)) u_sb_checker (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .issue_valid  (issue_valid),
    .issue_ready  (issue_ready),
    .issue_rs1    (issue_rs1),
    .issue_tag    (issue_tag),
    .lookup_busy  (lookup_busy),
    .lookup_hit   (lookup_hit),
    .commit_valid (commit_valid),
    .commit_we    (commit_we),
    .commit_exc   (commit_exc)
);

// File: tb/oow_scoreboard_bench.sv
module oow_scoreboard_bench;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             issue_valid = 1'b0;
    logic             issue_ready;
    logic [1:0]       issue_fu = '0;
    logic [3:0]       issue_op = '0;
    logic [4:0]       issue_rd = '0;
    logic [4:0]       issue_rs1 = '0;
    logic [4:0]       issue_rs2 = '0;
    logic [1:0]       issue_tag;
    logic [1:0]       lookup_busy;
    logic [1:0]       lookup_hit;
    logic [1:0][31:0] lookup_data;
    logic [2:0]       wb_valid = '0;
    logic [2:0][1:0]  wb_tag = '0;
    logic [2:0][31:0] wb_data = '0;
    logic [2:0]       wb_exc = '0;
    logic             commit_valid;
    logic [4:0]       commit_rd;
    logic [31:0]      commit_data;
    logic             commit_we;
    logic             commit_exc;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [4:0]  rd;
        logic [31:0] data;
        logic        we;
        logic        exc;
    } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    oow_scoreboard u_oow_scoreboard (
        .clk(clk), .rst(rst), .flush(flush),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_fu(issue_fu), .issue_op(issue_op), .issue_rd(issue_rd),
        .issue_rs1(issue_rs1), .issue_rs2(issue_rs2), .issue_tag(issue_tag),
        .lookup_busy(lookup_busy), .lookup_hit(lookup_hit), .lookup_data(lookup_data),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
        .commit_valid(commit_valid), .commit_rd(commit_rd), .commit_data(commit_data),
        .commit_we(commit_we), .commit_exc(commit_exc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        issue_valid = 1'b0;
        wb_valid    = '0;
        wb_exc      = '0;
        flush       = 1'b0;
    endtask

    task automatic set_issue(input logic [1:0] fu, input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        issue_valid = 1'b1;
        issue_fu    = fu;
        issue_op    = 4'h1;
        issue_rd    = rd;
        issue_rs1   = rs1;
        issue_rs2   = rs2;
        #1;
    endtask

    task automatic set_wb(input int port, input logic [1:0] tag, input logic [31:0] data, input logic exc);
        wb_valid[port] = 1'b1;
        wb_tag[port]   = tag;
        wb_data[port]  = data;
        wb_exc[port]   = exc;
    endtask

    task automatic expect_commit(input logic [4:0] rd, input logic [31:0] data, input logic we, input logic exc);
        exp_t e;
        e.rd = rd; e.data = data; e.we = we; e.exc = exc;
        expq.push_back(e);
    endtask

    // Monitor: compare every retirement against the expected queue (R5, R6).
    always @(negedge clk) begin
        if (!rst && commit_valid) begin
            if (expq.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 unexpected commit actual=rd%0d expected=none", commit_rd);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R5", "commit_rd", 32'(commit_rd), 32'(e.rd));
                chk("R4", "commit_data", commit_data, e.data);
                chk("R6", "commit_we", 32'(commit_we), 32'(e.we));
                chk("R9", "commit_exc", 32'(commit_exc), 32'(e.exc));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk("R1", "issue_ready", 32'(issue_ready), 1);
        chk("R1", "commit_valid", 32'(commit_valid), 0);
        chk("R1", "issue_tag", 32'(issue_tag), 0);

        set_issue(2'd1, 5'd1, 5'd2, 5'd0);   chk("R2", "tag ld", 32'(issue_tag), 0); tick();
        set_issue(2'd2, 5'd2, 5'd2, 5'd2);   chk("R2", "tag mul", 32'(issue_tag), 1); tick();
        set_issue(2'd0, 5'd3, 5'd0, 5'd0);   chk("R2", "tag alu", 32'(issue_tag), 2); tick();

        set_wb(0, 2'd2, 32'h10, 1'b0);
        set_wb(2, 2'd1, 32'hAAAA, 1'b0);
        tick();

        issue_rs1 = 5'd2; #1;
        chk("R4", "fwd x2 hit", 32'(lookup_hit[0]), 1);
        chk("R4", "fwd x2 data", lookup_data[0], 32'hAAAA);

        set_issue(2'd0, 5'd2, 5'd3, 5'd1);
        chk("R7", "rs1 x3 hit", 32'(lookup_hit[0]), 1);
        chk("R7", "rs1 x3 data", lookup_data[0], 32'h10);
        chk("R7", "rs2 x1 busy", 32'(lookup_busy[1]), 1);
        chk("R2", "tag add", 32'(issue_tag), 3);
        tick();

        chk("R3", "full ready", 32'(issue_ready), 0);
        issue_rs1 = 5'd2; #1;
        chk("R7", "youngest x2 busy", 32'(lookup_busy[0]), 1);
        chk("R7", "youngest x2 no hit", 32'(lookup_hit[0]), 0);
        issue_rs1 = 5'd0; #1;
        chk("R8", "x0 busy", 32'(lookup_busy[0]), 0);
        chk("R8", "x0 hit", 32'(lookup_hit[0]), 0);

        set_issue(2'd0, 5'd5, 5'd0, 5'd0);
        tick();
        repeat (2) tick();
        chk("R5", "blocked head", 32'(commit_valid), 0);

        expect_commit(5'd1, 32'h5555, 1'b1, 1'b0);
        expect_commit(5'd2, 32'hAAAA, 1'b1, 1'b0);
        expect_commit(5'd3, 32'h10, 1'b1, 1'b0);
        expect_commit(5'd2, 32'hAABA, 1'b1, 1'b0);
        set_wb(1, 2'd0, 32'h5555, 1'b0);
        set_wb(0, 2'd3, 32'hAABA, 1'b0);
        tick();
        repeat (6) tick();
        chk("R5", "drained", 32'(expq.size()), 0);
        chk("R3", "ignored issue tag", 32'(issue_tag), 0);
        chk("R3", "ready after drain", 32'(issue_ready), 1);

        expect_commit(5'd0, 32'h11, 1'b0, 1'b0);
        expect_commit(5'd7, 32'h77, 1'b1, 1'b0);
        set_issue(2'd0, 5'd0, 5'd0, 5'd0); chk("R2", "wrap tag", 32'(issue_tag), 0); tick();
        set_issue(2'd0, 5'd7, 5'd0, 5'd0); tick();
        issue_rs1 = 5'd0; #1;
        chk("R8", "x0 in flight busy", 32'(lookup_busy[0]), 0);
        chk("R8", "x0 in flight hit", 32'(lookup_hit[0]), 0);
        set_wb(0, 2'd0, 32'h11, 1'b0);
        set_wb(2, 2'd1, 32'h77, 1'b0);
        set_wb(1, 2'd2, 32'hDEAD, 1'b1);
        tick();
        repeat (4) tick();
        chk("R6", "x0 pair drained", 32'(expq.size()), 0);

        set_issue(2'd1, 5'd9, 5'd0, 5'd0); chk("R11", "tag reuse", 32'(issue_tag), 2); tick();
        issue_rs1 = 5'd9; #1;
        chk("R11", "stale slot busy", 32'(lookup_busy[0]), 1);
        chk("R11", "stale slot hit", 32'(lookup_hit[0]), 0);
        set_issue(2'd0, 5'd10, 5'd0, 5'd0); tick();
        set_wb(0, 2'd3, 32'h10, 1'b0);
        tick();
        chk("R5", "younger waits", 32'(commit_valid), 0);
        expect_commit(5'd9, 32'hBAD, 1'b0, 1'b1);
        set_wb(1, 2'd2, 32'hBAD, 1'b1);
        tick();
        chk("R9", "exc commit shown", 32'(commit_exc), 1);
        chk("R6", "exc no write", 32'(commit_we), 0);
        tick();
        repeat (3) tick();
        chk("R9", "halted commit", 32'(commit_valid), 0);
        chk("R9", "halted issue", 32'(issue_ready), 0);

        flush = 1'b1;
        tick();
        issue_rs1 = 5'd10; #1;
        chk("R10", "ready", 32'(issue_ready), 1);
        chk("R10", "commit", 32'(commit_valid), 0);
        chk("R10", "tag", 32'(issue_tag), 0);
        chk("R10", "lookup hit", 32'(lookup_hit[0]), 0);
        chk("R10", "lookup busy", 32'(lookup_busy[0]), 0);
        repeat (2) tick();
        chk("R5", "queue empty", 32'(expq.size()), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule